// File: doc/BRIEF.md
# External FIFO Bus Port

This block moves 16-bit words between an internal requester and an external FIFO device. The bus to the FIFO has only a data path and separate read and write strobes. There is no address and no latch strobe. The external FIFO has a full flag and an empty flag. When its enable is set, the full flag holds off writes and the empty flag holds off reads. A hold-off watchdog bounds how long a transfer may wait.

The requester offers one transfer at a time. The block accepts it when `req_ready` is high. It waits until the relevant flag allows the transfer, drives the active strobe for two clocks, and then pulses `rsp_done`. If the hold-off lasts for the programmed maximum number of clocks, the transfer is dropped without a strobe and `rsp_timeout` pulses instead. A small configuration register holds the flag enables, the strobe polarities and the maximum-wait value. The flag bits and the wait value each have their own write strobe.

Top module: `efifo_port`

## Requirements
- R1: An accepted write that is not held off drives the write strobe at its active level for exactly 2 clocks. `rsp_done` pulses for one clock 5 clocks after the accepting edge.
- R2: During a write, `bus_doe` is high with `bus_dout` equal to the accepted word while the strobe is active, and for one more clock after the strobe returns to idle.
- R3: An accepted read that is not held off drives the read strobe at its active level for exactly 2 clocks. The word on `bus_din` during the last strobe clock appears on `rsp_rdata`, and `rsp_done` pulses 4 clocks after the accepting edge. A read never activates the write strobe.
- R4: When the full-enable flag is set, a write is held off with no strobe for every clock in which `fifo_full` is high.
- R5: When the empty-enable flag is set, a read is held off with no strobe for every clock in which `fifo_empty` is high.
- R6: When a flag's enable is clear, that flag is ignored and the transfer runs with no hold-off.
- R7: When the number of held-off clocks reaches a nonzero maximum-wait value M, the transfer ends with no strobe. `rsp_timeout` pulses for one clock, M+1 clocks after the accepting edge, and `rsp_done` does not pulse.
- R8: A maximum-wait value of 0 disables the watchdog, and a transfer may be held off indefinitely with no timeout.
- R9: The maximum-wait value resets to 255. The flag enables and the polarity bits reset to 0.
- R10: A polarity bit of 0 makes its strobe active low, idling at 1. A polarity bit of 1 makes it active high, idling at 0. `cfg_wr_high` selects the write strobe and `cfg_rd_high` the read strobe.
- R11: The hold-off count starts from zero for every transfer and counts only held-off clocks.
- R12: `req_ready` is low from the accepting edge until the transfer ends, and is never high while a strobe is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_flags_we | input | 1 | Load the flag enables and polarity bits |
| cfg_full_en | input | 1 | Enable write hold-off by the full flag |
| cfg_empty_en | input | 1 | Enable read hold-off by the empty flag |
| cfg_wr_high | input | 1 | Write strobe is active high |
| cfg_rd_high | input | 1 | Read strobe is active high |
| cfg_wait_we | input | 1 | Load the maximum-wait value |
| cfg_max_wait | input | 8 | Maximum held-off clocks, 0 means no limit |
| req_valid | input | 1 | Transfer request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_wdata | input | 16 | Word to write |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_done | output | 1 | One-clock pulse when a transfer finishes |
| rsp_timeout | output | 1 | One-clock pulse when a transfer is dropped |
| rsp_rdata | output | 16 | Last word read |
| fifo_full | input | 1 | External FIFO full flag |
| fifo_empty | input | 1 | External FIFO empty flag |
| bus_din | input | 16 | Data from the external FIFO |
| bus_dout | output | 16 | Data to the external FIFO |
| bus_doe | output | 1 | Output enable for `bus_dout` |
| bus_wr | output | 1 | Write strobe pin |
| bus_rd | output | 1 | Read strobe pin |

## Verification
Writes and reads are run with no hold-off, with a hold-off of a few clocks that is then released, and with a hold-off that never ends. Completion latency and strobe counts tell the free path apart from the stalled path and from the dropped path. Each flag is raised with its enable clear, which shows that an ignored flag adds no cycles. The watchdog is tried at the reset limit of 255, at a small limit of 3, and at 0 with a 300-clock stall, which separates the reset value, the exact expiry cycle and the unlimited case. Two back-to-back stalled writes, each shorter than the limit but longer than half of it, show that the hold-off count restarts for every transfer. Both polarity settings are checked at the idle levels and during strobes.

// File: rtl/efifo_pkg.sv
package efifo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_STROBE,
        ST_HOLD
    } state_e;

    typedef struct packed {
        logic full_en;
        logic empty_en;
        logic wr_high;
        logic rd_high;
    } flags_t;

endpackage

// File: rtl/efifo_cfg_reg.sv
module efifo_cfg_reg
    import efifo_pkg::*;
#(
    parameter int WAIT_W = 8,
    parameter logic [WAIT_W-1:0] WAIT_RST = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flags_we,
    input  flags_t            flags_in,
    input  logic              wait_we,
    input  logic [WAIT_W-1:0] wait_in,
    output flags_t            flags_q,
    output logic [WAIT_W-1:0] max_wait_q
);

    typedef struct packed {
        flags_t            flags;
        logic [WAIT_W-1:0] max_wait;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (flags_we) cfg_d.flags = flags_in;
        if (wait_we)  cfg_d.max_wait = wait_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.flags    <= '0;
            cfg_q.max_wait <= WAIT_RST;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign flags_q    = cfg_q.flags;
    assign max_wait_q = cfg_q.max_wait;

endmodule

// File: rtl/efifo_holdoff.sv
module efifo_holdoff #(
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              stall,
    input  logic [WAIT_W-1:0] max_wait,
    output logic              expire
);

    logic [WAIT_W-1:0] cnt_d, cnt_q;
    logic [WAIT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + {{WAIT_W{1'b0}}, 1'b1};

    // A zero limit never expires; otherwise expiry hits on the Mth held-off clock.
    assign expire = stall && (max_wait != '0) && (cnt_inc == {1'b0, max_wait});

    always_comb begin
        cnt_d = cnt_q;
        if (clear)      cnt_d = '0;
        else if (stall) cnt_d = cnt_inc[WAIT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

endmodule

// File: rtl/efifo_strobe_drv.sv
module efifo_strobe_drv #(
    parameter int N_STB = 2
) (
    input  logic [N_STB-1:0] active,
    input  logic [N_STB-1:0] high,
    output logic [N_STB-1:0] pin
);

    for (genvar i = 0; i < N_STB; i++) begin : g_pin
        assign pin[i] = high[i] ? active[i] : ~active[i];
    end

endmodule

// File: rtl/efifo_port.sv
module efifo_port
    import efifo_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int WAIT_W     = 8,
    parameter int STROBE_CYC = 2,
    parameter int HOLD_CYC   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_flags_we,
    input  logic              cfg_full_en,
    input  logic              cfg_empty_en,
    input  logic              cfg_wr_high,
    input  logic              cfg_rd_high,
    input  logic              cfg_wait_we,
    input  logic [WAIT_W-1:0] cfg_max_wait,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              rsp_done,
    output logic              rsp_timeout,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic [DATA_W-1:0] bus_din,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_doe,
    output logic              bus_wr,
    output logic              bus_rd
);

    localparam int MAX_CYC = (STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] STB_LAST  = CNT_W'(STROBE_CYC - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);

    typedef struct packed {
        state_e            state;
        logic [CNT_W-1:0]  cnt;
        logic              write;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              done;
        logic              tout;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    flags_t            flags_in, flags_q;
    logic [WAIT_W-1:0] max_wait_q;
    logic              stall, ho_stall, ho_clear, expire;
    logic [1:0]        stb_act, stb_high, stb_pin;

    assign flags_in = '{full_en: cfg_full_en, empty_en: cfg_empty_en,
                        wr_high: cfg_wr_high, rd_high: cfg_rd_high};

    efifo_cfg_reg #(.WAIT_W(WAIT_W)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .flags_we   (cfg_flags_we),
        .flags_in   (flags_in),
        .wait_we    (cfg_wait_we),
        .wait_in    (cfg_max_wait),
        .flags_q    (flags_q),
        .max_wait_q (max_wait_q)
    );

    assign stall = ctl_q.write ? (flags_q.full_en  && fifo_full)
                               : (flags_q.empty_en && fifo_empty);
    assign ho_stall = (ctl_q.state == ST_WAIT) && stall;
    assign ho_clear = (ctl_q.state == ST_IDLE);

    efifo_holdoff #(.WAIT_W(WAIT_W)) u_holdoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ho_clear),
        .stall    (ho_stall),
        .max_wait (max_wait_q),
        .expire   (expire)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        ctl_d.tout = 1'b0;
        case (ctl_q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.state = ST_WAIT;
                    ctl_d.write = req_write;
                    ctl_d.wdata = req_wdata;
                end
            end
            ST_WAIT: begin
                if (!stall) begin
                    ctl_d.state = ST_STROBE;
                    ctl_d.cnt   = '0;
                end else if (expire) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.tout  = 1'b1;
                end
            end
            ST_STROBE: begin
                if (ctl_q.cnt == STB_LAST) begin
                    ctl_d.cnt = '0;
                    if (ctl_q.write) begin
                        ctl_d.state = ST_HOLD;
                    end else begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.rdata = bus_din;
                        ctl_d.done  = 1'b1;
                    end
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_HOLD: begin
                if (ctl_q.cnt == HOLD_LAST) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.done  = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state <= ST_IDLE;
            ctl_q.cnt   <= '0;
            ctl_q.write <= 1'b0;
            ctl_q.wdata <= '0;
            ctl_q.rdata <= '0;
            ctl_q.done  <= 1'b0;
            ctl_q.tout  <= 1'b0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign stb_act[0]  = (ctl_q.state == ST_STROBE) &&  ctl_q.write;
    assign stb_act[1]  = (ctl_q.state == ST_STROBE) && !ctl_q.write;
    assign stb_high[0] = flags_q.wr_high;
    assign stb_high[1] = flags_q.rd_high;

    efifo_strobe_drv #(.N_STB(2)) u_stb (
        .active (stb_act),
        .high   (stb_high),
        .pin    (stb_pin)
    );

    assign bus_wr      = stb_pin[0];
    assign bus_rd      = stb_pin[1];
    assign bus_doe     = ctl_q.write &&
                         ((ctl_q.state == ST_STROBE) || (ctl_q.state == ST_HOLD));
    assign bus_dout    = ctl_q.wdata;
    assign req_ready   = (ctl_q.state == ST_IDLE);
    assign rsp_done    = ctl_q.done;
    assign rsp_timeout = ctl_q.tout;
    assign rsp_rdata   = ctl_q.rdata;

endmodule

// File: rtl/efifo_port_chk.sv
module efifo_port_chk #(
    parameter int WAIT_W     = 8,
    parameter int STROBE_CYC = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              full_en,
    input logic              empty_en,
    input logic              wr_high,
    input logic              rd_high,
    input logic [WAIT_W-1:0] max_wait,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic              bus_doe,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_timeout
);

    logic wr_act, rd_act, any_act;
    logic [7:0] run_q;

    assign wr_act  = (bus_wr == wr_high);
    assign rd_act  = (bus_rd == rd_high);
    assign any_act = wr_act || rd_act;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       run_q <= '0;
        else if (any_act) run_q <= run_q + 8'd1;
        else              run_q <= '0;
    end

    AST_STROBE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_act) |-> (run_q == 8'(STROBE_CYC))); // R1

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wr_act) |-> bus_doe); // R2

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_act && rd_act)); // R3

    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_act) |-> !($past(full_en) && $past(fifo_full))); // R4

    AST_EMPTY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_act) |-> !($past(empty_en) && $past(fifo_empty))); // R5

    AST_TOUT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_timeout |-> (!rsp_done && !any_act && !$past(any_act))); // R7

    AST_NO_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (max_wait == '0 && $past(max_wait) == '0) |-> !rsp_timeout); // R8

    AST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        any_act |-> !req_ready); // R12

endmodule

bind efifo_port efifo_port_chk #(.WAIT_W(WAIT_W), .STROBE_CYC(STROBE_CYC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .full_en     (flags_q.full_en),
    .empty_en    (flags_q.empty_en),
    .wr_high     (flags_q.wr_high),
    .rd_high     (flags_q.rd_high),
    .max_wait    (max_wait_q),
    .fifo_full   (fifo_full),
    .fifo_empty  (fifo_empty),
    .bus_wr      (bus_wr),
    .bus_rd      (bus_rd),
    .bus_doe     (bus_doe),
    .req_ready   (req_ready),
    .rsp_done    (rsp_done),
    .rsp_timeout (rsp_timeout)
);

// File: tb/efifo_port_test.sv
module efifo_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_flags_we = 0, cfg_full_en = 0, cfg_empty_en = 0;
    logic        cfg_wr_high = 0, cfg_rd_high = 0, cfg_wait_we = 0;
    logic [7:0]  cfg_max_wait = 0;
    logic        req_valid = 0, req_write = 0;
    logic [15:0] req_wdata = 0;
    logic        req_ready, rsp_done, rsp_timeout;
    logic [15:0] rsp_rdata;
    logic        fifo_full = 0, fifo_empty = 0;
    logic [15:0] bus_din = 16'h0000;
    logic [15:0] bus_dout;
    logic        bus_doe, bus_wr, bus_rd;

    int n_chk = 0;
    int n_bad = 0;
    logic wr_pol = 0, rd_pol = 0;

    always #5 clk = ~clk;

    efifo_port uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_flags_we(cfg_flags_we), .cfg_full_en(cfg_full_en),
        .cfg_empty_en(cfg_empty_en), .cfg_wr_high(cfg_wr_high),
        .cfg_rd_high(cfg_rd_high), .cfg_wait_we(cfg_wait_we),
        .cfg_max_wait(cfg_max_wait),
        .req_valid(req_valid), .req_write(req_write), .req_wdata(req_wdata),
        .req_ready(req_ready), .rsp_done(rsp_done), .rsp_timeout(rsp_timeout),
        .rsp_rdata(rsp_rdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .bus_din(bus_din),
        .bus_dout(bus_dout), .bus_doe(bus_doe), .bus_wr(bus_wr), .bus_rd(bus_rd)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic set_flags(input bit fe, input bit ee, input bit wh, input bit rh);
        @(negedge clk);
        cfg_full_en = fe; cfg_empty_en = ee; cfg_wr_high = wh; cfg_rd_high = rh;
        cfg_flags_we = 1;
        @(negedge clk);
        cfg_flags_we = 0;
        wr_pol = wh; rd_pol = rh;
    endtask

    task automatic set_wait(input logic [7:0] v);
        @(negedge clk);
        cfg_max_wait = v; cfg_wait_we = 1;
        @(negedge clk);
        cfg_wait_we = 0;
    endtask

    // Runs one transfer. The flag is raised before the accepting edge when
    // flag_negs != 0, and lowered at negedge number flag_negs after it
    // (never when negative), which gives flag_negs-1 held-off clocks.
    task automatic xfer(input bit wr, input logic [15:0] d, input int flag_negs,
                        output int cycles, output int own_stb, output int other_stb,
                        output bit done, output bit tout, output bit hold_ok,
                        output bit busy_ok);
        bit prev_act = 0;
        cycles = 0; own_stb = 0; other_stb = 0; done = 0; tout = 0;
        hold_ok = 0; busy_ok = 1;
        @(negedge clk);
        req_valid = 1; req_write = wr; req_wdata = d;
        if (flag_negs != 0) begin
            if (wr) fifo_full = 1; else fifo_empty = 1;
        end
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        for (int n = 1; n <= 2000; n++) begin
            bit w_act, r_act, own;
            w_act = (bus_wr == wr_pol);
            r_act = (bus_rd == rd_pol);
            own   = wr ? w_act : r_act;
            if (own) own_stb++;
            if (wr ? r_act : w_act) other_stb++;
            if (own && (!wr || !bus_doe || bus_dout != d)) hold_ok = 0;
            if (wr && prev_act && !own && bus_doe && bus_dout == d) hold_ok = 1;
            if (!rsp_done && !rsp_timeout && req_ready) busy_ok = 0;
            prev_act = own;
            if (rsp_done || rsp_timeout) begin
                done = rsp_done; tout = rsp_timeout; cycles = n;
                break;
            end
            if (n == flag_negs) begin
                fifo_full = 0; fifo_empty = 0;
            end
            @(negedge clk);
        end
        fifo_full = 0; fifo_empty = 0;
        @(negedge clk);
        if (rsp_done || rsp_timeout) busy_ok = 0;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check(req_ready == 1, "R12 ready after reset", req_ready, 1);
        check(rsp_done == 0 && rsp_timeout == 0, "R9 no response after reset",
              {rsp_done, rsp_timeout}, 0);
        check(bus_wr == 1 && bus_rd == 1, "R10 low-active idle after reset",
              {bus_wr, bus_rd}, 3);
        check(bus_doe == 0, "R2 no drive after reset", bus_doe, 0);
    endtask

    task automatic t_reset_limit;
        int c, os, xs; bit dn, to, ho, bo;
        set_flags(1, 0, 0, 0);
        xfer(1, 16'h1111, -1, c, os, xs, dn, to, ho, bo);
        check(to && !dn, "R9 reset limit times out", to, 1);
        check(c == 256, "R9 reset limit is 255 clocks", c, 256);
        check(os == 0, "R7 no strobe on timeout", os, 0);
    endtask

    task automatic t_plain_write;
        int c, os, xs; bit dn, to, ho, bo;
        set_flags(0, 0, 0, 0);
        xfer(1, 16'hA5C3, 0, c, os, xs, dn, to, ho, bo);
        check(dn && !to, "R1 write done", dn, 1);
        check(c == 5, "R1 write latency", c, 5);
        check(os == 2, "R1 write strobe width", os, 2);
        check(ho, "R2 data held one clock past strobe", ho, 1);
        check(bo, "R12 busy during write", bo, 1);
    endtask

    task automatic t_plain_read;
        int c, os, xs; bit dn, to, ho, bo;
        bus_din = 16'h3C5A;
        xfer(0, 16'h0, 0, c, os, xs, dn, to, ho, bo);
        check(dn && !to, "R3 read done", dn, 1);
        check(c == 4, "R3 read latency", c, 4);
        check(os == 2, "R3 read strobe width", os, 2);
        check(xs == 0, "R3 no write strobe in read", xs, 0);
        check(rsp_rdata == 16'h3C5A, "R3 read data", rsp_rdata, 16'h3C5A);
    endtask

    task automatic t_stalls;
        int c, os, xs; bit dn, to, ho, bo;
        set_flags(1, 1, 0, 0);
        set_wait(8'd20);
        xfer(1, 16'h0F0F, 5, c, os, xs, dn, to, ho, bo);
        check(dn && c == 9, "R4 write held 4 clocks", c, 9);
        check(os == 2, "R4 one strobe after release", os, 2);
        bus_din = 16'hBEEF;
        xfer(0, 16'h0, 4, c, os, xs, dn, to, ho, bo);
        check(dn && c == 7, "R5 read held 3 clocks", c, 7);
        check(rsp_rdata == 16'hBEEF, "R5 read data after stall", rsp_rdata, 16'hBEEF);
    endtask

    task automatic t_ignored;
        int c, os, xs; bit dn, to, ho, bo;
        set_flags(0, 0, 0, 0);
        set_wait(8'd3);
        xfer(1, 16'h1234, -1, c, os, xs, dn, to, ho, bo);
        check(dn && !to && c == 5, "R6 full ignored when disabled", c, 5);
        xfer(0, 16'h0, -1, c, os, xs, dn, to, ho, bo);
        check(dn && !to && c == 4, "R6 empty ignored when disabled", c, 4);
    endtask

    task automatic t_timeout;
        int c, os, xs; bit dn, to, ho, bo;
        set_flags(1, 1, 0, 0);
        set_wait(8'd3);
        xfer(1, 16'h5555, -1, c, os, xs, dn, to, ho, bo);
        check(to && !dn, "R7 write timeout pulse", to, 1);
        check(c == 4, "R7 timeout at limit", c, 4);
        check(os == 0 && !bus_doe, "R7 no strobe on timeout", os, 0);
        check(bo, "R7 single timeout pulse", bo, 1);
        xfer(0, 16'h0, -1, c, os, xs, dn, to, ho, bo);
        check(to && !dn && c == 4 && os == 0, "R7 read timeout", c, 4);
    endtask

    task automatic t_restart;
        int c, os, xs; bit dn, to, ho, bo;
        xfer(1, 16'h0001, 3, c, os, xs, dn, to, ho, bo);
        check(dn && !to && c == 7, "R11 first held write", c, 7);
        xfer(1, 16'h0002, 3, c, os, xs, dn, to, ho, bo);
        check(dn && !to && c == 7, "R11 count restarts", c, 7);
    endtask

    task automatic t_unlimited;
        int c, os, xs; bit dn, to, ho, bo;
        set_wait(8'd0);
        xfer(1, 16'h7777, 301, c, os, xs, dn, to, ho, bo);
        check(dn && !to, "R8 no timeout with limit 0", to, 0);
        check(c == 305, "R8 completes after 300 held clocks", c, 305);
    endtask

    task automatic t_polarity;
        int c, os, xs; bit dn, to, ho, bo;
        set_flags(0, 0, 1, 1);
        @(negedge clk);
        check(bus_wr == 0 && bus_rd == 0, "R10 high-active idle", {bus_wr, bus_rd}, 0);
        xfer(1, 16'hCAFE, 0, c, os, xs, dn, to, ho, bo);
        check(dn && os == 2 && ho, "R10 high-active write strobe", os, 2);
        xfer(0, 16'h0, 0, c, os, xs, dn, to, ho, bo);
        check(dn && os == 2 && xs == 0, "R10 high-active read strobe", os, 2);
        set_flags(0, 0, 1, 0);
        @(negedge clk);
        check(bus_wr == 0 && bus_rd == 1, "R10 mixed polarity idle", {bus_wr, bus_rd}, 1);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_reset_limit();
        t_plain_write();
        t_plain_read();
        t_stalls();
        t_ignored();
        t_timeout();
        t_restart();
        t_unlimited();
        t_polarity();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule